// File: doc/BRIEF.md
# Dual-Destination Register File with Bypass and Interlock

This block is the register file and hazard logic for a five-stage in-order integer pipeline whose instruction set includes a load with post-update addressing. That instruction forms its address as base plus a sign-extended immediate. It writes the memory word to a data destination and writes the same address back into the base register. Every instruction therefore carries up to two destinations: a primary one and a secondary one. The primary value is ready at the end of EX for ALU work, or at the end of MEM for loads. The secondary value (the updated base) is always ready at the end of EX.

Decode presents a descriptor each cycle, holding both destinations, a flag for a late primary and the two source registers. The block tracks these descriptors through EX, MEM and WB and reads two operands in decode. It produces a forwarding select for each EX operand and raises a stall for load-use hazards. While the stall is high the front end holds decode and the block puts a bubble into EX. Both writebacks normally commit in the same cycle through two write ports. A parameter selects an underpipelined variant with a single write port, in which the second write is deferred by one cycle.

Top module: `dual_dest_hazard_unit`

## Requirements
- R1: After reset every register reads zero, `stall` is low and both forwarding selects are 0.
- R2: With `DUAL_WP`=1, the primary and secondary writebacks of one instruction both commit at the end of its WB cycle.
- R3: A decode read of a register written in the same cycle returns the value being written.
- R4: Register 0 always reads zero, ignores writes from either port, never produces a forwarding select other than 0 and never causes a stall.
- R5: Select encoding: 0 = register file, 1 = EX/MEM primary, 2 = EX/MEM secondary, 3 = MEM/WB primary, 4 = MEM/WB secondary. The EX/MEM stage wins over MEM/WB, which wins over the register file. Within a stage the primary wins when both destinations match.
- R6: An instruction's secondary destination is a forwarding source from EX/MEM (select 2) and from MEM/WB (select 4).
- R7: If the decode instruction reads the late primary destination of the instruction in EX, `stall` is high for exactly one cycle and EX receives a bubble. The held instruction then forwards from MEM/WB primary (select 3).
- R8: A dependence on a secondary destination never raises `stall` in the two-port configuration.
- R9: `ldu_alias` is high while the decode descriptor names the same register as both primary and secondary. In that case the primary data is the value that commits.
- R10: With `DUAL_WP`=0, an instruction with a secondary destination stalls for one cycle when it reaches EX. Its secondary write commits one cycle after its primary. A decode read during its WB cycle already sees the updated base, and so does a read during the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | Decode source register 1 (0 = unused) |
| id_rs2 | input | AW | Decode source register 2 (0 = unused) |
| id_pd_vld | input | 1 | Decode instruction has a primary destination |
| id_pd | input | AW | Primary destination register |
| id_pd_late | input | 1 | Primary value ready only at end of MEM (load) |
| id_sd_vld | input | 1 | Decode instruction has a secondary destination (updated base) |
| id_sd | input | AW | Secondary destination register |
| wb_pd_data | input | DW | Primary result of the instruction in WB |
| wb_sd_data | input | DW | Secondary result of the instruction in WB |
| id_rdata1 | output | DW | Decode read data for source 1 |
| id_rdata2 | output | DW | Decode read data for source 2 |
| ex_fwd1 | output | 3 | Forwarding select for EX operand 1 |
| ex_fwd2 | output | 3 | Forwarding select for EX operand 2 |
| stall | output | 1 | Hold decode; bubble inserted into EX |
| ldu_alias | output | 1 | Decode descriptor names one register as both destinations |

## Verification
On every cycle the assertions check these properties: register 0 reads and forwards as zero, a stall is always followed by a bubble in EX, and no EX operand is left facing a load result that is still in MEM. They also check that the structural stall never repeats back to back, and that a deferred secondary write always finds the write port free. Only the directed scenarios can show the actual values. These include which select wins when producers in several stages match, what a register holds after a same-register writeback, and which cycle a deferred base write becomes visible in. They also show that a base-only dependence passes without a stall in the two-port build while the one-port build stalls.

// File: rtl/ddh_pkg.sv
package ddh_pkg;
  localparam int FWD_W = 3;

  typedef enum logic [FWD_W-1:0] {
    FWD_NONE    = 3'd0,
    FWD_MEM_PRI = 3'd1,
    FWD_MEM_SEC = 3'd2,
    FWD_WB_PRI  = 3'd3,
    FWD_WB_SEC  = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/ddh_regfile.sv
module ddh_regfile #(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter bit COMMIT1 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd0,
  output logic [DW-1:0] rd1
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  // Write-before-read: port 0 outranks port 1, then the stored value.
  function automatic logic [DW-1:0] read_pick(
    input logic [AW-1:0] ra, input logic [DW-1:0] stored,
    input logic w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
    input logic w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    if (ra == '0)            return '0;
    if (w0 && (a0 == ra))    return d0;
    if (w1 && (a1 == ra))    return d1;
    return stored;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (COMMIT1 && we1 && (wa1 != '0)) regs[wa1] <= wd1;
      if (we0 && (wa0 != '0))            regs[wa0] <= wd0;
    end
  end

  assign rd0 = read_pick(ra0, regs[ra0], we0, wa0, wd0, we1, wa1, wd1);
  assign rd1 = read_pick(ra1, regs[ra1], we0, wa0, wd0, we1, wa1, wd1);
endmodule

// File: rtl/ddh_dest_pipe.sv
module ddh_dest_pipe #(
  parameter int WIDTH = 13,
  parameter int NSTG  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bubble,
  input  logic [WIDTH-1:0] in_desc,
  output logic [WIDTH-1:0] stg [NSTG]
);
  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    logic [WIDTH-1:0] nxt;
    if (k == 0) begin : g_head
      assign nxt = bubble ? '0 : in_desc;
    end else begin : g_body
      assign nxt = stg[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= nxt;
    end
  end
endmodule

// File: rtl/ddh_fwd_sel.sv
module ddh_fwd_sel #(
  parameter int AW = 5
) (
  input  logic          [AW-1:0] rs,
  input  logic                   mem_pv,
  input  logic          [AW-1:0] mem_pd,
  input  logic                   mem_sv,
  input  logic          [AW-1:0] mem_sd,
  input  logic                   wb_pv,
  input  logic          [AW-1:0] wb_pd,
  input  logic                   wb_sv,
  input  logic          [AW-1:0] wb_sd,
  output logic [ddh_pkg::FWD_W-1:0] sel
);
  import ddh_pkg::*;

  function automatic logic dest_hit(input logic v, input logic [AW-1:0] d,
                                    input logic [AW-1:0] r);
    return v && (d == r) && (r != '0);
  endfunction

  function automatic fwd_src_e pick(input logic [AW-1:0] r);
    if (dest_hit(mem_pv, mem_pd, r)) return FWD_MEM_PRI;
    if (dest_hit(mem_sv, mem_sd, r)) return FWD_MEM_SEC;
    if (dest_hit(wb_pv,  wb_pd,  r)) return FWD_WB_PRI;
    if (dest_hit(wb_sv,  wb_sd,  r)) return FWD_WB_SEC;
    return FWD_NONE;
  endfunction

  assign sel = pick(rs);
endmodule

// File: rtl/ddh_hazard.sv
module ddh_hazard #(
  parameter int AW      = 5,
  parameter bit DUAL_WP = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          ex_pv,
  input  logic [AW-1:0] ex_pd,
  input  logic          ex_late,
  input  logic          ex_sv,
  output logic          stall_lu,
  output logic          stall_wp
);
  function automatic logic late_use(input logic [AW-1:0] r);
    return ex_pv && ex_late && (ex_pd != '0) && (ex_pd == r);
  endfunction

  assign stall_lu = late_use(id_rs1) || late_use(id_rs2);

  if (DUAL_WP) begin : g_two_port
    assign stall_wp = 1'b0;
  end else begin : g_one_port
    assign stall_wp = ex_sv;
  end
endmodule

// File: rtl/dual_dest_hazard_unit.sv
module dual_dest_hazard_unit #(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter bit DUAL_WP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_pd_vld,
  input  logic [AW-1:0] id_pd,
  input  logic          id_pd_late,
  input  logic          id_sd_vld,
  input  logic [AW-1:0] id_sd,
  input  logic [DW-1:0] wb_pd_data,
  input  logic [DW-1:0] wb_sd_data,
  output logic [DW-1:0] id_rdata1,
  output logic [DW-1:0] id_rdata2,
  output logic [2:0]    ex_fwd1,
  output logic [2:0]    ex_fwd2,
  output logic          stall,
  output logic          ldu_alias
);
  localparam int NSTG   = 3;
  localparam int DEST_W = 3 + 2 * AW;

  // Stage-tracked destination descriptors (0 = EX, 1 = MEM, 2 = WB).
  logic [DEST_W-1:0] dest_stg [NSTG];
  logic              st_pv   [NSTG];
  logic [AW-1:0]     st_pd   [NSTG];
  logic              st_late [NSTG];
  logic              st_sv   [NSTG];
  logic [AW-1:0]     st_sd   [NSTG];

  logic          stall_lu, stall_wp;
  logic [AW-1:0] ex_rs1, ex_rs2;

  assign stall = stall_lu | stall_wp;

  ddh_dest_pipe #(.WIDTH(DEST_W), .NSTG(NSTG)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .bubble  (stall),
    .in_desc ({id_pd_vld, id_pd, id_pd_late, id_sd_vld, id_sd}),
    .stg     (dest_stg)
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_unpack
    assign {st_pv[k], st_pd[k], st_late[k], st_sv[k], st_sd[k]} = dest_stg[k];
  end

  // Named per-stage views used by the logic and the checker.
  logic          ex_pv, ex_late, ex_sv;
  logic [AW-1:0] ex_pd;
  logic          mem_pv, mem_late, mem_sv;
  logic [AW-1:0] mem_pd, mem_sd;
  logic          wb_pv, wb_late, wb_sv;
  logic [AW-1:0] wb_pd, wb_sd;

  assign ex_pv    = st_pv[0];   assign ex_pd  = st_pd[0];
  assign ex_late  = st_late[0]; assign ex_sv  = st_sv[0];
  assign mem_pv   = st_pv[1];   assign mem_pd = st_pd[1];
  assign mem_late = st_late[1]; assign mem_sv = st_sv[1];
  assign mem_sd   = st_sd[1];
  assign wb_pv    = st_pv[2];   assign wb_pd  = st_pd[2];
  assign wb_late  = st_late[2]; assign wb_sv  = st_sv[2];
  assign wb_sd    = st_sd[2];

  // Source registers travel only as far as EX.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rs1 <= '0;
      ex_rs2 <= '0;
    end else if (stall) begin
      ex_rs1 <= '0;
      ex_rs2 <= '0;
    end else begin
      ex_rs1 <= id_rs1;
      ex_rs2 <= id_rs2;
    end
  end

  ddh_hazard #(.AW(AW), .DUAL_WP(DUAL_WP)) u_hazard (
    .id_rs1   (id_rs1),
    .id_rs2   (id_rs2),
    .ex_pv    (ex_pv),
    .ex_pd    (ex_pd),
    .ex_late  (ex_late),
    .ex_sv    (ex_sv),
    .stall_lu (stall_lu),
    .stall_wp (stall_wp)
  );

  logic [AW-1:0] ex_rs   [2];
  logic [2:0]    fwd_sel [2];
  assign ex_rs[0] = ex_rs1;
  assign ex_rs[1] = ex_rs2;

  for (genvar op = 0; op < 2; op++) begin : g_fwd
    ddh_fwd_sel #(.AW(AW)) u_sel (
      .rs     (ex_rs[op]),
      .mem_pv (mem_pv),
      .mem_pd (mem_pd),
      .mem_sv (mem_sv),
      .mem_sd (mem_sd),
      .wb_pv  (wb_pv),
      .wb_pd  (wb_pd),
      .wb_sv  (wb_sv),
      .wb_sd  (wb_sd),
      .sel    (fwd_sel[op])
    );
  end

  assign ex_fwd1 = fwd_sel[0];
  assign ex_fwd2 = fwd_sel[1];

  assign ldu_alias = id_pd_vld && id_sd_vld && (id_pd == id_sd);

  // Writeback requests; the secondary yields when both name one register.
  logic wb_pri_we, wb_sec_we;
  assign wb_pri_we = wb_pv && (wb_pd != '0);
  assign wb_sec_we = wb_sv && (wb_sd != '0) && !(wb_pv && (wb_pd == wb_sd));

  logic          we0, we1, pend_vld;
  logic [AW-1:0] wa0, wa1;
  logic [DW-1:0] wd0, wd1;

  assign we1 = wb_sec_we;
  assign wa1 = wb_sd;
  assign wd1 = wb_sd_data;

  if (DUAL_WP) begin : g_wp2
    assign pend_vld = 1'b0;
    assign we0      = wb_pri_we;
    assign wa0      = wb_pd;
    assign wd0      = wb_pd_data;
  end else begin : g_wp1
    logic          pend_q;
    logic [AW-1:0] pend_rd;
    logic [DW-1:0] pend_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q    <= 1'b0;
        pend_rd   <= '0;
        pend_data <= '0;
      end else begin
        pend_q    <= wb_sec_we;
        pend_rd   <= wb_sd;
        pend_data <= wb_sd_data;
      end
    end
    assign pend_vld = pend_q;
    assign we0      = pend_q | wb_pri_we;
    assign wa0      = pend_q ? pend_rd   : wb_pd;
    assign wd0      = pend_q ? pend_data : wb_pd_data;
  end

  ddh_regfile #(.AW(AW), .DW(DW), .COMMIT1(DUAL_WP)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we0   (we0),
    .wa0   (wa0),
    .wd0   (wd0),
    .we1   (we1),
    .wa1   (wa1),
    .wd1   (wd1),
    .ra0   (id_rs1),
    .ra1   (id_rs2),
    .rd0   (id_rdata1),
    .rd1   (id_rdata2)
  );
endmodule

// File: rtl/ddh_checker.sv
module ddh_checker #(
  parameter int AW      = 5,
  parameter int DW      = 32,
  parameter bit DUAL_WP = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          stall_wp,
  input logic          ex_pv,
  input logic          ex_sv,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic          mem_pv,
  input logic [AW-1:0] mem_pd,
  input logic          mem_late,
  input logic          mem_sv,
  input logic          wb_pv,
  input logic [AW-1:0] wb_pd,
  input logic          wb_late,
  input logic          wb_sv,
  input logic          pend_vld,
  input logic [2:0]    ex_fwd1,
  input logic [2:0]    ex_fwd2,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [DW-1:0] id_rdata1,
  input logic [DW-1:0] id_rdata2
);
  p_zero_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> (id_rdata1 == '0));
  p_zero_read2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs2 == '0) |-> (id_rdata2 == '0));
  p_zero_nofwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0) |-> (ex_fwd1 == 3'd0));
  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_pv && !ex_sv && ex_rs1 == '0 && ex_rs2 == '0));
  p_no_late_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_pv && mem_late && (mem_pd != '0) &&
      ((ex_rs1 == mem_pd) || (ex_rs2 == mem_pd))));
  p_wb_load_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_pv && wb_late && (wb_pd != '0) && (ex_rs2 == wb_pd) && !mem_pv && !mem_sv)
      |-> (ex_fwd2 == 3'd3));
  p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd1 <= 3'd4) && (ex_fwd2 <= 3'd4));
  p_wp_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_wp |=> !stall_wp);

  if (DUAL_WP == 0) begin : g_one_port_chk
    p_pend_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pend_vld |-> (!wb_pv && !wb_sv));
  end
endmodule

bind dual_dest_hazard_unit ddh_checker #(.AW(AW), .DW(DW), .DUAL_WP(DUAL_WP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .stall_wp  (stall_wp),
  .ex_pv     (ex_pv),
  .ex_sv     (ex_sv),
  .ex_rs1    (ex_rs1),
  .ex_rs2    (ex_rs2),
  .mem_pv    (mem_pv),
  .mem_pd    (mem_pd),
  .mem_late  (mem_late),
  .mem_sv    (mem_sv),
  .wb_pv     (wb_pv),
  .wb_pd     (wb_pd),
  .wb_late   (wb_late),
  .wb_sv     (wb_sv),
  .pend_vld  (pend_vld),
  .ex_fwd1   (ex_fwd1),
  .ex_fwd2   (ex_fwd2),
  .id_rs1    (id_rs1),
  .id_rs2    (id_rs2),
  .id_rdata1 (id_rdata1),
  .id_rdata2 (id_rdata2)
);

// File: tb/tb_dual_dest_hazard_unit.sv
`timescale 1ns/1ps
module tb_dual_dest_hazard_unit;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] id_rs1, id_rs2, id_pd, id_sd;
  logic          id_pd_vld, id_pd_late, id_sd_vld;
  logic [DW-1:0] wb_pd_data, wb_sd_data;

  logic [DW-1:0] rd1, rd2, u_rd1, u_rd2;
  logic [2:0]    f1, f2, u_f1, u_f2;
  logic          stl, u_stl, alias_o, u_alias;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dual_dest_hazard_unit #(.AW(AW), .DW(DW), .DUAL_WP(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_pd_vld(id_pd_vld), .id_pd(id_pd), .id_pd_late(id_pd_late),
    .id_sd_vld(id_sd_vld), .id_sd(id_sd),
    .wb_pd_data(wb_pd_data), .wb_sd_data(wb_sd_data),
    .id_rdata1(rd1), .id_rdata2(rd2), .ex_fwd1(f1), .ex_fwd2(f2),
    .stall(stl), .ldu_alias(alias_o));

  dual_dest_hazard_unit #(.AW(AW), .DW(DW), .DUAL_WP(1'b0)) dut_up (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_pd_vld(id_pd_vld), .id_pd(id_pd), .id_pd_late(id_pd_late),
    .id_sd_vld(id_sd_vld), .id_sd(id_sd),
    .wb_pd_data(wb_pd_data), .wb_sd_data(wb_sd_data),
    .id_rdata1(u_rd1), .id_rdata2(u_rd2), .ex_fwd1(u_f1), .ex_fwd2(u_f2),
    .stall(u_stl), .ldu_alias(u_alias));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic pv, input logic [AW-1:0] pd, input logic late,
                       input logic sv, input logic [AW-1:0] sd,
                       input logic [AW-1:0] r1, input logic [AW-1:0] r2);
    id_pd_vld = pv; id_pd = pd; id_pd_late = late;
    id_sd_vld = sv; id_sd = sd; id_rs1 = r1; id_rs2 = r2;
  endtask

  task automatic nop();  drive(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic tick(); @(posedge clk); #1; endtask
  task automatic mid();  @(negedge clk); endtask

  task automatic do_reset();
    nop();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    drive(0, 0, 0, 0, 0, 5, 9);
    mid();
    chk("R1 rdata1", rd1, 0);
    chk("R1 rdata2", rd2, 0);
    chk("R1 stall", {31'd0, stl}, 0);
    chk("R1 fwd1", {29'd0, f1}, 0);
    chk("R1 fwd2", {29'd0, f2}, 0);
    tick();
  endtask

  task automatic t_dual_write();
    do_reset();
    wb_pd_data = 32'hA1A1_0003; wb_sd_data = 32'hB2B2_0004;
    drive(1, 3, 1, 1, 4, 0, 0); tick();   // EX
    nop(); tick();                         // MEM
    nop(); tick();                         // WB this cycle
    drive(0, 0, 0, 0, 0, 3, 4);
    mid();
    chk("R3 same-cycle read pri", rd1, 32'hA1A1_0003);
    chk("R3 same-cycle read sec", rd2, 32'hB2B2_0004);
    tick();
    mid();
    chk("R2 committed pri", rd1, 32'hA1A1_0003);
    chk("R2 committed sec", rd2, 32'hB2B2_0004);
    tick();
  endtask

  task automatic t_priority();
    do_reset();
    wb_pd_data = 32'h77; wb_sd_data = 32'h0;
    drive(1, 7, 0, 0, 0, 0, 0); tick();
    drive(1, 7, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 7, 0); tick();
    nop();
    mid();
    chk("R5 EX/MEM beats MEM/WB", {29'd0, f1}, 1);
    tick();
    do_reset();
    drive(1, 6, 0, 0, 0, 0, 0); tick();
    nop(); tick();
    drive(0, 0, 0, 0, 0, 6, 6); tick();
    nop();
    mid();
    chk("R5 MEM/WB primary op1", {29'd0, f1}, 3);
    chk("R5 MEM/WB primary op2", {29'd0, f2}, 3);
    tick(); tick(); tick();
    drive(0, 0, 0, 0, 0, 6, 0); tick();
    nop();
    mid();
    chk("R5 register file source", {29'd0, f1}, 0);
    tick();
  endtask

  task automatic t_secondary();
    do_reset();
    drive(1, 8, 1, 1, 9, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 9, 0);
    mid();
    chk("R8 base dependence no stall", {31'd0, stl}, 0);
    tick();
    drive(0, 0, 0, 0, 0, 0, 9);
    mid();
    chk("R6 EX/MEM secondary", {29'd0, f1}, 2);
    chk("R8 no stall second reader", {31'd0, stl}, 0);
    tick();
    nop();
    mid();
    chk("R6 MEM/WB secondary", {29'd0, f2}, 4);
    tick();
  endtask

  task automatic t_load_use();
    do_reset();
    drive(1, 10, 1, 1, 11, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 10);
    mid();
    chk("R7 load-use stall", {31'd0, stl}, 1);
    tick();
    mid();
    chk("R7 stall lasts one cycle", {31'd0, stl}, 0);
    chk("R7 bubble op1", {29'd0, f1}, 0);
    chk("R7 bubble op2", {29'd0, f2}, 0);
    tick();
    nop();
    mid();
    chk("R7 forward loaded data", {29'd0, f2}, 3);
    tick();
  endtask

  task automatic t_zero_reg();
    do_reset();
    wb_pd_data = 32'hFFFF_FFFF; wb_sd_data = 32'hEEEE_EEEE;
    drive(1, 0, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    mid();
    chk("R4 no forward of x0", {29'd0, f1}, 0);
    drive(1, 0, 1, 1, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    mid();
    chk("R4 x0 never stalls", {31'd0, stl}, 0);
    tick(); tick(); tick();
    mid();
    chk("R4 x0 reads zero", rd1, 0);
    tick();
  endtask

  task automatic t_alias();
    do_reset();
    wb_pd_data = 32'hAAAA_0012; wb_sd_data = 32'hBBBB_0012;
    drive(1, 12, 1, 1, 12, 0, 0);
    mid();
    chk("R9 alias flagged", {31'd0, alias_o}, 1);
    tick();
    nop();
    mid();
    chk("R9 alias clear", {31'd0, alias_o}, 0);
    tick(); tick(); tick();
    drive(0, 0, 0, 0, 0, 12, 0);
    mid();
    chk("R9 loaded data wins", rd1, 32'hAAAA_0012);
    tick();
  endtask

  task automatic t_one_port();
    do_reset();
    wb_pd_data = 32'h1111; wb_sd_data = 32'h2222;
    drive(1, 13, 1, 1, 14, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 14, 0);
    mid();
    chk("R10 one-port stall", {31'd0, u_stl}, 1);
    chk("R8 two-port no stall", {31'd0, stl}, 0);
    tick();
    mid();
    chk("R10 stall one cycle", {31'd0, u_stl}, 0);
    tick();
    drive(0, 0, 0, 0, 0, 14, 13);
    mid();
    chk("R10 fwd MEM/WB secondary", {29'd0, u_f1}, 4);
    chk("R10 base visible in WB cycle", u_rd1, 32'h2222);
    chk("R10 primary in WB cycle", u_rd2, 32'h1111);
    tick();
    mid();
    chk("R10 deferred write cycle", u_rd1, 32'h2222);
    tick();
    mid();
    chk("R10 base committed", u_rd1, 32'h2222);
    chk("R10 primary committed", u_rd2, 32'h1111);
    tick();
  endtask

  initial begin
    wb_pd_data = '0; wb_sd_data = '0;
    nop();
    t_reset();
    t_dual_write();
    t_priority();
    t_secondary();
    t_load_use();
    t_zero_reg();
    t_alias();
    t_one_port();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule